// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Generator

This block produces the shift clock for a synchronous serial port from the system clock. The divide runs in two stages. The first stage is set by a prescale register written over a simple register port. That register keeps only even values, because its least significant bit is always zero. The second stage divides by one plus an 8-bit serial clock rate value that comes from a separate control input. The full output period is therefore the prescale value multiplied by (1 + rate) system clocks.

The output clock has a 50% duty cycle. Each of its edges comes with a strobe that is one system clock wide, so the shift logic can act on the edges. A new prescale or rate value is taken only when an output period has completed, so no short pulse can appear. A stored prescale of zero keeps the generator idle with its output low. Dropping the enable clears both counters and pulls the output low.

Top module: `bclk_gen`

## Requirements
- R1: After a synchronous active-low reset, the stored prescale is 0x00, `bclk`, `rise_stb` and `fall_stb` are low, and a read at offset 0x010 returns 0.
- R2: A write at byte offset 0x010 stores `wdata[7:0]` with bit 0 forced to 0. A read at offset 0x010 returns the stored value in bits 7:0 and zero in bits 31:8. Example: writing 0xFFFFFF07 reads back as 0x00000006.
- R3: A write at any other offset leaves the stored prescale unchanged, and a read at any other offset returns 0.
- R4: While the prescale value in use is 0, `bclk` stays low and neither strobe is asserted. Writing 0 while the clock is running stops it at the end of the current period.
- R5: With `enable` high and a nonzero prescale P, the first cycle loads P and SCR. After that, `bclk` toggles every H = (P/2)·(1+SCR) system clocks, starting low, which gives a period of P·(1+SCR) and a 50% duty cycle.
- R6: `rise_stb` is high for exactly the one cycle in which `bclk` has just gone from 0 to 1. `fall_stb` does the same for the 1-to-0 transition. The two strobes are never high together.
- R7: Changes to the prescale register or to `scr` take effect only after the falling edge that ends the current period. The new half period starts with the next low phase.
- R8: When `enable` is sampled low, `bclk`, the strobes and both counters are cleared at the next clock edge. Raising `enable` again starts a fresh period from a load cycle.
- R9: The second stage covers the full range 1 to 256 (SCR 0 to 255). The first stage covers prescale 2 to 254. Examples: P=2 with SCR=255 gives H=256, and P=254 with SCR=0 gives H=127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` (combinational) |
| scr | input | 8 | Serial clock rate; second stage divides by scr+1 |
| enable | input | 1 | Generator enable |
| bclk | output | 1 | Generated bit clock |
| rise_stb | output | 1 | One-cycle strobe for a rising edge of `bclk` |
| fall_stb | output | 1 | One-cycle strobe for a falling edge of `bclk` |

## Verification
The bench writes odd prescale values and writes to a neighbouring offset. A design that keeps bit 0, or that decodes the address loosely, would read back the wrong value. It changes the prescale and the rate in the middle of a period and compares every edge against a behavioural model. A design that picks up new values right away would produce a short high or low phase that does not match the model. It also runs both ends of the ranges (rate 255 and prescale 254), where an off-by-one counter limit would shift every edge. It drops `enable` mid-phase and writes zero while the clock is running, to catch a design that does not return low promptly or that never stops.

// File: rtl/bclk_pkg.sv
// Shared constants for the bit-clock generator.
package bclk_pkg;
    localparam int          PRESC_W      = 8;
    localparam int          RATE_W       = 8;
    localparam int          ADDR_W       = 12;
    localparam int          DATA_W       = 32;
    localparam logic [11:0] PRESC_OFFSET = 12'h010;
endpackage

// File: rtl/bclk_prescale_reg.sv
// Prescale register: stores even divisors only and decodes one offset.
// Assumes: the read data is combinational on addr; reserved bits read as zero.
module bclk_prescale_reg #(
    parameter int              ADDR_W = 12,
    parameter int              DATA_W = 32,
    parameter int              PW     = 8,
    parameter logic [ADDR_W-1:0] OFFSET = 12'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [PW-1:0]     presc_q
);
    logic hit;
    assign hit = (addr == OFFSET);

    // Store the written divisor with bit 0 cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            presc_q <= '0;
        else if (wr_en && hit)
            presc_q <= {wdata[PW-1:1], 1'b0};
    end

    // Return the stored value at the decoded offset and zero elsewhere.
    always_comb begin
        rdata = '0;
        if (hit)
            rdata[PW-1:0] = presc_q;
    end

    assert_write_lsb_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (presc_q == {$past(wdata[PW-1:1]), 1'b0}));

    assert_other_offset_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(presc_q));
endmodule

// File: rtl/bclk_div_stage.sv
// Generic divider stage: counts advance pulses and emits a tick every limit+1 of them.
// Assumes: limit is held steady while the stage is counting (clr drops it to zero otherwise).
module bclk_div_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = adv && (cnt == limit);

    // Count advance pulses and wrap to zero on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (adv)
            cnt <= tick ? '0 : cnt + 1'b1;
    end

    assert_cnt_within_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |-> (cnt <= limit));
endmodule

// File: rtl/bclk_out_ctrl.sv
// Output control: latches the divisors at period boundaries, drives the clock and the strobes.
// Assumes: toggle comes from the cascaded divider stages and is one cycle wide.
module bclk_out_ctrl #(
    parameter int PW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [PW-1:0] presc_q,
    input  logic [SW-1:0] scr,
    input  logic          toggle,
    output logic          running,
    output logic [PW-2:0] p_limit,
    output logic [SW-1:0] s_limit,
    output logic          bclk,
    output logic          rise_stb,
    output logic          fall_stb
);
    logic [PW-2:0] act_p;
    logic [SW-1:0] act_s;

    assign p_limit = act_p - 1'b1;
    assign s_limit = act_s;

    // Load divisors when idle or at period end, toggle the clock, raise the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            running  <= 1'b0;
            act_p    <= '0;
            act_s    <= '0;
            bclk     <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
            if (!running) begin
                if (presc_q != '0) begin
                    running <= 1'b1;
                    act_p   <= presc_q[PW-1:1];
                    act_s   <= scr;
                end
            end else if (toggle) begin
                if (!bclk) begin
                    bclk     <= 1'b1;
                    rise_stb <= 1'b1;
                end else begin
                    bclk     <= 1'b0;
                    fall_stb <= 1'b1;
                    if (presc_q == '0) begin
                        running <= 1'b0;
                    end else begin
                        act_p <= presc_q[PW-1:1];
                        act_s <= scr;
                    end
                end
            end
        end
    end

    assert_no_midperiod_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && running && !(toggle && bclk)) |=> ($stable(act_p) && $stable(act_s)));

    assert_disable_forces_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bclk && !running));

    assert_zero_prescale_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && presc_q == '0) |=> (!bclk && !rise_stb && !fall_stb));
endmodule

// File: rtl/bclk_gen.sv
// Top: prescale register, first stage (P/2 clocks), second stage (SCR+1 ticks), output control.
// Assumes: synchronous active-low reset; bclk toggles on every second-stage tick.
module bclk_gen
    import bclk_pkg::*;
#(
    parameter int                ADDR_W = bclk_pkg::ADDR_W,
    parameter int                DATA_W = bclk_pkg::DATA_W,
    parameter int                PW     = PRESC_W,
    parameter int                SW     = RATE_W,
    parameter logic [ADDR_W-1:0] OFFSET = PRESC_OFFSET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [SW-1:0]     scr,
    input  logic              enable,
    output logic              bclk,
    output logic              rise_stb,
    output logic              fall_stb
);
    logic [PW-1:0] presc_q;
    logic          running;
    logic [PW-2:0] p_limit;
    logic [SW-1:0] s_limit;
    logic          tick1;
    logic          tick2;
    logic          stage_clr;

    assign stage_clr = !enable || !running;

    bclk_prescale_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW(PW), .OFFSET(OFFSET)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .presc_q(presc_q)
    );

    bclk_div_stage #(.W(PW-1)) u_stage1 (
        .clk(clk), .rst_n(rst_n), .clr(stage_clr), .adv(running),
        .limit(p_limit), .tick(tick1)
    );

    bclk_div_stage #(.W(SW)) u_stage2 (
        .clk(clk), .rst_n(rst_n), .clr(stage_clr), .adv(tick1),
        .limit(s_limit), .tick(tick2)
    );

    bclk_out_ctrl #(.PW(PW), .SW(SW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .presc_q(presc_q), .scr(scr),
        .toggle(tick2), .running(running), .p_limit(p_limit), .s_limit(s_limit),
        .bclk(bclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb, fall_stb}));

    assert_rise_has_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> rise_stb);

    assert_fall_has_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk) |-> fall_stb);
endmodule

// File: tb/bclk_gen_bench.sv
// Bench: behavioural per-cycle model of the bit clock, compared on every cycle.
module bclk_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  scr = '0;
    logic        enable = 1'b0;
    logic        bclk, rise_stb, fall_stb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase_req = "R1";

    // model state
    int m_presc = 0;
    bit m_run = 0;
    int m_cnt = 0;
    int m_half = 0;
    bit m_out = 0;
    bit m_rs = 0;
    bit m_fs = 0;

    always #2.5 clk = ~clk;

    bclk_gen u_bclk_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .scr(scr), .enable(enable), .bclk(bclk),
        .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    // Reference model, advanced at each rising edge from the inputs held since the last falling edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_presc = 0; m_run = 0; m_cnt = 0; m_half = 0; m_out = 0; m_rs = 0; m_fs = 0;
        end else begin
            m_rs = 0; m_fs = 0;
            if (!enable) begin
                m_run = 0; m_cnt = 0; m_out = 0;
            end else if (!m_run) begin
                if (m_presc != 0) begin
                    m_run = 1; m_cnt = 0;
                    m_half = (m_presc / 2) * (int'(scr) + 1);
                end
            end else begin
                m_cnt++;
                if (m_cnt == m_half) begin
                    m_cnt = 0;
                    if (!m_out) begin
                        m_out = 1; m_rs = 1;
                    end else begin
                        m_out = 0; m_fs = 1;
                        if (m_presc == 0) m_run = 0;
                        else m_half = (m_presc / 2) * (int'(scr) + 1);
                    end
                end
            end
            if (wr_en && addr == 12'h010) m_presc = int'(wdata[7:0] & 8'hFE);
        end
    end

    // Compare outputs with the model in the middle of every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (bclk !== m_out) begin
                errors++;
                $display("FAIL %s bclk: actual %0b expected %0b (cycle %0d)", phase_req, bclk, m_out, cycles);
            end
            checks++;
            if (rise_stb !== m_rs || fall_stb !== m_fs) begin
                errors++;
                $display("FAIL R6 strobes during %s: actual %0b%0b expected %0b%0b (cycle %0d)",
                         phase_req, rise_stb, fall_stb, m_rs, m_fs, cycles);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check_val(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 12'h010;
    endtask

    task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check_val(req, "rdata", rdata, exp);
        addr = 12'h010;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_val("R1", "bclk after reset", {31'b0, bclk}, 32'h0);
        check_val("R1", "strobes after reset", {30'b0, rise_stb, fall_stb}, 32'h0);
        rd("R1", 12'h010, 32'h0);

        phase_req = "R2";
        wr(12'h010, 32'hFFFF_FF07);
        rd("R2", 12'h010, 32'h0000_0006);
        wr(12'h010, 32'h0000_00FF);
        rd("R2", 12'h010, 32'h0000_00FE);

        phase_req = "R3";
        wr(12'h014, 32'h0000_00AA);
        rd("R3", 12'h010, 32'h0000_00FE);
        rd("R3", 12'h014, 32'h0);
        wr(12'h000, 32'h0000_0010);
        rd("R3", 12'h010, 32'h0000_00FE);

        phase_req = "R4";
        wr(12'h010, 32'h0);
        enable = 1'b1;
        run(50);
        check_val("R4", "bclk idle", {31'b0, bclk}, 32'h0);

        phase_req = "R5";
        scr = 8'd0;
        wr(12'h010, 32'h2);
        run(40);
        scr = 8'd3;
        wr(12'h010, 32'h6);
        run(150);

        phase_req = "R7";
        run(5);
        scr = 8'd1;
        run(7);
        wr(12'h010, 32'h9);
        run(200);

        phase_req = "R8";
        run(3);
        enable = 1'b0;
        @(negedge clk);
        check_val("R8", "bclk after disable", {31'b0, bclk}, 32'h0);
        run(5);
        enable = 1'b1;
        run(100);

        phase_req = "R9";
        scr = 8'd255;
        wr(12'h010, 32'h2);
        run(1200);
        scr = 8'd0;
        wr(12'h010, 32'hFE);
        run(700);

        phase_req = "R4";
        wr(12'h010, 32'h0);
        run(400);
        check_val("R4", "stopped after zero write", {31'b0, bclk}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule